// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Connect Controller

This block decides when a card plugged into a live backplane may join its two-wire bus (a clock line and a data line) to the backplane's bus. It works on sampled line levels. Until supply is good it keeps the two sides apart and ignores all bus activity. It then assumes it arrived in the middle of a transfer. It waits on the backplane side for a stop condition or for a stretch of bus idle. Before joining, it confirms that both card-side lines are high.

When joined, the block behaves like an open-drain wired-AND between the two sides. For each line, a low driven by devices on one side turns on a pull-down enable on the other side. A line is released on both sides only when nobody on either side holds it low, so clock stretching, arbitration and acknowledge pass through. A rise-time accelerator enable comes up together with the join and drops with it. If supply is lost, the join is broken in the same cycle.

Top module: `busjoin_ctrl`

## Requirements
- R1: While `pwr_good_a` is low, the state is 0 (lockout), `joined` and `accel_en` are 0, all four pull-down enables are 0, and backplane bus activity has no effect.
- R2: When `cfg_dual_supply` is 1, lockout is also held while `pwr_good_b` is low. When `cfg_dual_supply` is 0, `pwr_good_b` is ignored.
- R3: One clock edge after supply becomes good, the state leaves lockout for 1 (waiting for stop or idle).
- R4: A stop is a rising edge of synchronized backplane data while synchronized backplane clock is high. A falling edge of data in that condition (a start) is not a stop. A stop in state 1 moves the state to 2 (check).
- R5: Bus idle is reported after backplane clock and data have both been high for more than `idle_limit` consecutive cycles while in state 1. A low on either line restarts the count. Idle moves the state to 2.
- R6: In state 2, the block moves to 3 (joined) if both synchronized card-side lines are high. Otherwise it returns to 1. State 3 is reached only from state 2.
- R7: In state 3 with supply good, `joined` and `accel_en` are both 1.
- R8: While joined, each side's pull-down enable for a line is 1 exactly when the opposite side's external level for that line is low. The enable follows the input two clock edges after the input changes, through the input synchronizer. While not joined, every pull-down enable is 0.
- R9: While joined, a line whose inputs are high on both sides has no pull-down enabled on either side.
- R10: Loss of supply drops `joined`, `accel_en` and all pull-down enables in the same cycle, with no clock edge needed. The state returns to 0 at the next edge.
- R11: `state_o` encodes lockout=0, waiting=1, check=2, joined=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good_a | input | 1 | Primary supply good |
| pwr_good_b | input | 1 | Secondary supply good |
| cfg_dual_supply | input | 1 | Require the secondary supply good flag as well |
| idle_limit | input | CNT_W | Idle threshold in cycles |
| card_scl_i | input | 1 | Card-side clock level driven externally |
| card_sda_i | input | 1 | Card-side data level driven externally |
| bp_scl_i | input | 1 | Backplane clock level driven externally |
| bp_sda_i | input | 1 | Backplane data level driven externally |
| card_scl_pd | output | 1 | Pull card-side clock low |
| card_sda_pd | output | 1 | Pull card-side data low |
| bp_scl_pd | output | 1 | Pull backplane clock low |
| bp_sda_pd | output | 1 | Pull backplane data low |
| joined | output | 1 | Sides are connected |
| accel_en | output | 1 | Rise-time accelerator enable |
| state_o | output | 2 | Controller state |

## Verification
Because the state is exposed, a wrong state is visible at `state_o` on the edge after the faulty transition. A join taken too early or too late also shows on `joined` within a cycle. A broken stop or idle detector shows up as the state staying at 1 after a stop, or as a premature 3 during a counted idle stretch that a clock pulse should have restarted. A fault in the wired-AND path appears two edges after an input change, as a wrong pull-down enable on the opposite side. Power-loss handling is checked one delta after the flag falls.

// File: rtl/busjoin_pkg.sv
package busjoin_pkg;

    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CHECK = 2'd2,
        ST_JOIN  = 2'd3
    } join_state_e;

    // line index inside the synchronized vector
    localparam int unsigned LN_CARD_SCL = 0;
    localparam int unsigned LN_CARD_SDA = 1;
    localparam int unsigned LN_BP_SCL   = 2;
    localparam int unsigned LN_BP_SDA   = 3;
    localparam int unsigned LN_COUNT    = 4;

endpackage

// File: rtl/busjoin_sync.sv
module busjoin_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // idle bus level is high, so the chain resets to ones
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/busjoin_watch.sv
module busjoin_watch #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [CNT_W-1:0] idle_limit,
    output logic             stop_seen,
    output logic             idle_seen
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             sda_prev;
        logic [CNT_W-1:0] cnt;
    } watch_t;

    watch_t d, q;
    logic   both_hi;

    always_comb begin
        both_hi  = scl_s & sda_s;
        d        = q;
        d.sda_prev = sda_s;
        if (clr || !both_hi)        d.cnt = '0;
        else if (q.cnt != CNT_MAX)  d.cnt = q.cnt + 1'b1;
        stop_seen = !clr && scl_s && sda_s && !q.sda_prev;
        idle_seen = !clr && both_hi && (q.cnt >= idle_limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{sda_prev: 1'b1, cnt: '0};
        else        q <= d;
    end
endmodule

// File: rtl/busjoin_wand.sv
module busjoin_wand (
    input  logic joined,
    input  logic card_s,
    input  logic bp_s,
    output logic card_pd,
    output logic bp_pd
);
    // each side's pull-down comes only from the opposite side's external level
    always_comb begin
        card_pd = joined & ~bp_s;
        bp_pd   = joined & ~card_s;
    end
endmodule

// File: rtl/busjoin_ctrl.sv
module busjoin_ctrl
    import busjoin_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good_a,
    input  logic             pwr_good_b,
    input  logic             cfg_dual_supply,
    input  logic [CNT_W-1:0] idle_limit,
    input  logic             card_scl_i,
    input  logic             card_sda_i,
    input  logic             bp_scl_i,
    input  logic             bp_sda_i,
    output logic             card_scl_pd,
    output logic             card_sda_pd,
    output logic             bp_scl_pd,
    output logic             bp_sda_pd,
    output logic             joined,
    output logic             accel_en,
    output logic [1:0]       state_o
);
    localparam int unsigned NLINES = LN_COUNT;
    localparam int unsigned NPAIRS = NLINES / 2;

    typedef struct packed {
        join_state_e st;
    } ctrl_t;

    ctrl_t d, q;

    logic [NLINES-1:0] raw_lines, sync_lines;
    logic              pwr_ok, stop_seen, idle_seen, watch_clr, join_now;
    logic [NPAIRS-1:0] card_pd_v, bp_pd_v;

    assign raw_lines[LN_CARD_SCL] = card_scl_i;
    assign raw_lines[LN_CARD_SDA] = card_sda_i;
    assign raw_lines[LN_BP_SCL]   = bp_scl_i;
    assign raw_lines[LN_BP_SDA]   = bp_sda_i;

    busjoin_sync #(.STAGES(SYNC_STAGES), .WIDTH(NLINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    assign watch_clr = (q.st != ST_WAIT);

    busjoin_watch #(.CNT_W(CNT_W)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (watch_clr),
        .scl_s     (sync_lines[LN_BP_SCL]),
        .sda_s     (sync_lines[LN_BP_SDA]),
        .idle_limit(idle_limit),
        .stop_seen (stop_seen),
        .idle_seen (idle_seen)
    );

    always_comb begin
        pwr_ok = pwr_good_a & (pwr_good_b | ~cfg_dual_supply);
        d      = q;
        if (!pwr_ok) begin
            d.st = ST_LOCK;
        end else begin
            case (q.st)
                ST_LOCK:  d.st = ST_WAIT;
                ST_WAIT:  if (stop_seen || idle_seen) d.st = ST_CHECK;
                ST_CHECK: d.st = (sync_lines[LN_CARD_SCL] && sync_lines[LN_CARD_SDA])
                                 ? ST_JOIN : ST_WAIT;
                default:  d.st = ST_JOIN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_LOCK};
        else        q <= d;
    end

    // supply loss breaks the join without waiting for an edge
    assign join_now = (q.st == ST_JOIN) && pwr_ok;
    assign joined   = join_now;
    assign accel_en = join_now;
    assign state_o  = q.st;

    // pair 0 = clock line, pair 1 = data line
    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        busjoin_wand u_wand (
            .joined (join_now),
            .card_s (sync_lines[p]),
            .bp_s   (sync_lines[p + NPAIRS]),
            .card_pd(card_pd_v[p]),
            .bp_pd  (bp_pd_v[p])
        );
    end

    assign card_scl_pd = card_pd_v[0];
    assign card_sda_pd = card_pd_v[1];
    assign bp_scl_pd   = bp_pd_v[0];
    assign bp_sda_pd   = bp_pd_v[1];
endmodule

// File: rtl/busjoin_ctrl_chk.sv
module busjoin_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good_a,
    input logic       pwr_good_b,
    input logic       cfg_dual_supply,
    input logic       joined,
    input logic       accel_en,
    input logic [1:0] state_o,
    input logic       card_scl_pd,
    input logic       card_sda_pd,
    input logic       bp_scl_pd,
    input logic       bp_sda_pd
);
    logic any_pd;
    assign any_pd = card_scl_pd | card_sda_pd | bp_scl_pd | bp_sda_pd;

    // R1, R10
    a_r10_primary_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_a |-> (!joined && !accel_en && !any_pd));

    // R2
    a_r2_second_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual_supply && !pwr_good_b) |-> (!joined && !accel_en && !any_pd));

    // R3
    a_r3_leave_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 2'd0 && state_o != 2'd0) |-> state_o == 2'd1);

    // R6
    a_r6_join_via_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_o == 2'd3) |-> $past(state_o) == 2'd2);

    // R8
    a_r8_no_pd_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !joined |-> !any_pd);
endmodule

bind busjoin_ctrl busjoin_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_good_a     (pwr_good_a),
    .pwr_good_b     (pwr_good_b),
    .cfg_dual_supply(cfg_dual_supply),
    .joined         (joined),
    .accel_en       (accel_en),
    .state_o        (state_o),
    .card_scl_pd    (card_scl_pd),
    .card_sda_pd    (card_sda_pd),
    .bp_scl_pd      (bp_scl_pd),
    .bp_sda_pd      (bp_sda_pd)
);

// File: tb/busjoin_ctrl_bench.sv
module busjoin_ctrl_bench;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good_a = 1'b0, pwr_good_b = 1'b0, cfg_dual_supply = 1'b0;
    logic [CNT_W-1:0] idle_limit = 16'd20;
    logic card_scl_i = 1'b1, card_sda_i = 1'b1, bp_scl_i = 1'b1, bp_sda_i = 1'b1;
    logic card_scl_pd, card_sda_pd, bp_scl_pd, bp_sda_pd, joined, accel_en;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    busjoin_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_busjoin_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pwr_good_a(pwr_good_a), .pwr_good_b(pwr_good_b),
        .cfg_dual_supply(cfg_dual_supply), .idle_limit(idle_limit),
        .card_scl_i(card_scl_i), .card_sda_i(card_sda_i),
        .bp_scl_i(bp_scl_i), .bp_sda_i(bp_sda_i),
        .card_scl_pd(card_scl_pd), .card_sda_pd(card_sda_pd),
        .bp_scl_pd(bp_scl_pd), .bp_sda_pd(bp_sda_pd),
        .joined(joined), .accel_en(accel_en), .state_o(state_o)
    );

    // {card_scl, card_sda, bp_scl, bp_sda, exp card_scl_pd, card_sda_pd, bp_scl_pd, bp_sda_pd}
    localparam logic [7:0] WAND_VEC [9] = '{
        8'b1111_0000, 8'b0111_0010, 8'b1011_0001, 8'b1101_1000,
        8'b1110_0100, 8'b0101_1010, 8'b1010_0101, 8'b0000_1111,
        8'b1111_0000
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_stop();
        bp_sda_i = 1'b0; tick(3);
        bp_sda_i = 1'b1;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset state", state_o, 0);
        chk("R1 reset joined", joined, 0);
        chk("R1 reset pulldowns", {card_scl_pd, card_sda_pd, bp_scl_pd, bp_sda_pd}, 0);

        // activity during lockout is ignored
        for (int i = 0; i < 4; i++) begin
            pulse_stop(); tick(3);
        end
        tick(30);
        chk("R1 activity in lockout", state_o, 0);

        cfg_dual_supply = 1'b1; pwr_good_a = 1'b1;
        tick(5);
        chk("R2 second flag low keeps lockout", state_o, 0);
        pwr_good_b = 1'b1;
        tick(1);
        chk("R3 leave lockout to wait", state_o, 1);

        // R5: idle counted, restarted by a clock low
        tick(9);
        chk("R5 idle not yet", state_o, 1);
        bp_scl_i = 1'b0; tick(2);
        bp_scl_i = 1'b1; tick(12);
        chk("R5 idle count restarted", state_o, 1);
        tick(30);
        chk("R5 R6 idle then join", state_o, 3);
        chk("R7 joined", joined, 1);
        chk("R7 accel", accel_en, 1);

        // R8 R9: wired-AND table
        foreach (WAND_VEC[i]) begin
            {card_scl_i, card_sda_i, bp_scl_i, bp_sda_i} = WAND_VEC[i][7:4];
            tick(2);
            chk("R8 R9 wired-AND pulldowns",
                {card_scl_pd, card_sda_pd, bp_scl_pd, bp_sda_pd}, int'(WAND_VEC[i][3:0]));
        end
        chk("R7 stays joined", state_o, 3);

        // R10: supply loss
        bp_scl_i = 1'b0; tick(2);
        chk("R8 card clock pulled", card_scl_pd, 1);
        pwr_good_a = 1'b0; #1;
        chk("R10 joined drops at once", joined, 0);
        chk("R10 accel drops at once", accel_en, 0);
        chk("R10 pulldown drops at once", card_scl_pd, 0);
        tick(1);
        chk("R10 back to lockout", state_o, 0);
        bp_scl_i = 1'b1;

        // R4: stop detection, start ignored
        idle_limit = 16'd1000; cfg_dual_supply = 1'b0; pwr_good_b = 1'b0;
        tick(3);
        pwr_good_a = 1'b1;
        tick(1);
        chk("R2 second flag ignored when not required", state_o, 1);
        bp_sda_i = 1'b0; tick(5);
        chk("R4 start is not stop", state_o, 1);
        bp_sda_i = 1'b1; tick(5);
        chk("R4 stop then join", state_o, 3);

        // R6: check fails when a card line is low
        pwr_good_a = 1'b0; card_sda_i = 1'b0; tick(1);
        pwr_good_a = 1'b1; tick(1);
        chk("R11 wait encoding", state_o, 1);
        pulse_stop(); tick(8);
        chk("R6 check fails back to wait", state_o, 1);
        chk("R6 not joined", joined, 0);
        card_sda_i = 1'b1; tick(3);
        pulse_stop(); tick(6);
        chk("R6 check passes", state_o, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule